// File: doc/BRIEF.md
# Programmable Tapped Delay Line

A clocked digital delay element. A single-bit input travels down a shift register, and the output is taken from the tap picked by a seven-bit delay code, giving 128 settings. Each code bit carries a binary weight: bit n adds 2^n clock steps on top of a one-cycle registered path. The code therefore sets a delay of code+1 enabled clock cycles.

The delay code and an eighth cascade bit are held in a code register. The register follows its inputs while the hold control is low and keeps its value while hold is high. Two force inputs override the held delay code with all zeros or all ones. The held eighth bit does not change this stage's delay. It drives a complementary output pair, so a wider delay code can be spread over several chained stages. A gate input freezes the whole line: input changes are ignored, the line does not advance and the output keeps its value.

Top module: `prog_delay_line`

## Requirements
- R1: Synchronous reset clears the output, both cascade outputs and the whole line, so a single input pulse applied after reset gives exactly one output pulse and nothing before it.
- R2: With the gate high, `dout` after a clock edge equals the `din` value sampled code+1 gated edges earlier, where bit n of the 7-bit delay code (`code_in[6:0]`) adds 2^n cycles, so code 0 gives 1 cycle and code 127 gives 128 cycles.
- R3: While `hold` is low, each clock edge copies `code_in` into the code register, and the new delay applies from the next edge.
- R4: While `hold` is high, the code register keeps its value and changes on `code_in` have no effect on the delay or the cascade outputs.
- R5: While `force_min` is high, the delay is one cycle whatever the held code.
- R6: While `force_max` is high and `force_min` is low, the delay is 128 cycles whatever the held code.
- R7: When both force inputs are high, `force_min` wins and the delay is one cycle.
- R8: Bit 7 of `code_in` is stored with the delay code. `casc` shows its held value and `casc_n` its complement from the first load after reset, and the bit has no effect on this stage's delay.
- R9: While `en` is low, `dout` holds its value, `din` is ignored and the line does not advance. Delay is counted only in cycles with `en` high.
- R10: A code loaded with `hold` low gives its delay to an input edge sampled two or more edges after the loading edge, whatever code was used before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Gate: high lets the line advance |
| din | input | 1 | Data input |
| code_in | input | 8 | [6:0] delay code, [7] cascade bit |
| hold | input | 1 | High keeps the code register, low loads it |
| force_min | input | 1 | Force the delay code to zero |
| force_max | input | 1 | Force the delay code to all ones |
| dout | output | 1 | Delayed data output |
| casc | output | 1 | Held cascade bit |
| casc_n | output | 1 | Complement of held cascade bit |

## Verification
A wrong bit in the code register shows as a pulse that comes out a power-of-two number of cycles early or late. A single pulse per setting finds it within 128 cycles of launch, and the measured delay for each weight also shows whether delays grow with the code. A corrupted line stage shows as a stray or missing output bit exactly when that stage's contents reach the selected tap. A random stream compared against a reference history finds it within one delay length. A wrong cascade bit is visible on the complementary pair one edge after the load.

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              din,
  input  logic [CODE_W:0]   code_in,
  input  logic              hold,
  input  logic              force_min,
  input  logic              force_max,
  output logic              dout,
  output logic              casc,
  output logic              casc_n
);
  localparam int DEPTH = 1 << CODE_W;

  logic [CODE_W:0]    held;
  logic [CODE_W-1:0]  eff;
  logic [DEPTH-2:0]   line;
  logic [DEPTH-1:0]   taps;

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      casc_n <= 1'b0;
    end else if (!hold) begin
      held   <= code_in;
      casc_n <= ~code_in[CODE_W];
    end
  end

  assign casc = held[CODE_W];
  assign eff  = force_min ? '0 : (force_max ? '1 : held[CODE_W-1:0]);
  assign taps = {line, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
      dout <= 1'b0;
    end else if (en) begin
      line <= taps[DEPTH-2:0];
      dout <= taps[eff];
    end
  end
endmodule

// File: rtl/prog_delay_line_chk.sv
module prog_delay_line_chk #(
  parameter int CODE_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            din,
  input logic [CODE_W:0] code_in,
  input logic            hold,
  input logic            force_min,
  input logic            force_max,
  input logic            dout,
  input logic            casc,
  input logic            casc_n,
  input logic [CODE_W:0] held
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (dout == 1'b0 && casc == 1'b0 && casc_n == 1'b0)); // R1
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !hold |=> held == $past(code_in)); // R3
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst) hold |=> $stable(held)); // R4
  AST_MIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) (en && force_min) |=> dout == $past(din)); // R5
  AST_MIN_WINS: assert property (@(posedge clk) disable iff (rst) (en && force_min && force_max) |=> dout == $past(din)); // R7
  AST_CASC_PAIR: assert property (@(posedge clk) disable iff (rst) !hold |=> casc != casc_n); // R8
  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(dout)); // R9
endmodule

bind prog_delay_line prog_delay_line_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .din(din), .code_in(code_in), .hold(hold),
  .force_min(force_min), .force_max(force_max), .dout(dout), .casc(casc),
  .casc_n(casc_n), .held(held)
);

// File: tb/prog_delay_line_tb.sv
module prog_delay_line_tb;
  logic clk = 1'b0, rst = 1'b1, en = 1'b1, din = 1'b0;
  logic [7:0] code_in = '0;
  logic hold = 1'b1, force_min = 1'b0, force_max = 1'b0;
  logic dout, casc, casc_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  prog_delay_line u_dut (
    .clk(clk), .rst(rst), .en(en), .din(din), .code_in(code_in), .hold(hold),
    .force_min(force_min), .force_max(force_max), .dout(dout), .casc(casc), .casc_n(casc_n)
  );

  // {code[7:0], force_min, force_max, expected delay[7:0]}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {8'd0,   1'b0, 1'b0, 8'd1},
    {8'd1,   1'b0, 1'b0, 8'd2},
    {8'd2,   1'b0, 1'b0, 8'd3},
    {8'd4,   1'b0, 1'b0, 8'd5},
    {8'd8,   1'b0, 1'b0, 8'd9},
    {8'd16,  1'b0, 1'b0, 8'd17},
    {8'd32,  1'b0, 1'b0, 8'd33},
    {8'd64,  1'b0, 1'b0, 8'd65},
    {8'd127, 1'b0, 1'b0, 8'd128},
    {8'h85,  1'b0, 1'b0, 8'd6},
    {8'd10,  1'b1, 1'b0, 8'd1},
    {8'd3,   1'b0, 1'b1, 8'd128},
    {8'd3,   1'b1, 1'b1, 8'd1}
  };

  // reference history model
  logic [255:0] hist;
  logic exp_q;
  int ref_code = 0;
  always @(posedge clk) begin
    if (rst) begin
      hist  = '0;
      exp_q = 1'b0;
    end else if (en) begin
      hist  = {hist[254:0], din};
      exp_q = hist[ref_code];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] c);
    @(negedge clk);
    code_in = c;
    hold = 1'b0;
    @(negedge clk);
    hold = 1'b1;
  endtask

  task automatic idle(input int n);
    din = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_delay(output int d);
    d = 0;
    din = 1'b1;
    @(negedge clk);
    din = 1'b0;
    d = 1;
    while (!dout && d < 200) begin
      @(negedge clk);
      d++;
    end
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 dout", dout, 0);
    chk("R1 casc", casc, 0);
    chk("R1 casc_n", casc_n, 0);
    rst = 1'b0;
    idle(2);
    pulse_delay(d);
    chk("R1 single pulse after reset (code 0)", d, 1);

    // table: delays per code and force (R2, R5, R6, R7, R8)
    for (int i = 0; i < NV; i++) begin
      force_min = VEC[i][9];
      force_max = VEC[i][8];
      load(VEC[i][17:10]);
      chk("R8 casc", casc, VEC[i][17]);
      chk("R8 casc_n", casc_n, !VEC[i][17]);
      idle(130);
      pulse_delay(d);
      chk(VEC[i][9] ? "R5/R7 forced min delay" : VEC[i][8] ? "R6 forced max delay" : "R2 tap delay", d, VEC[i][7:0]);
      force_min = 1'b0;
      force_max = 1'b0;
    end

    // R4: hold high ignores code_in
    load(8'd10);
    code_in = 8'hB2;
    idle(130);
    chk("R4 casc unchanged", casc, 0);
    pulse_delay(d);
    chk("R4 held delay", d, 11);

    // R3 / R10: new code applies to an edge two edges after load
    load(8'd0);
    idle(130);
    load(8'd40);
    idle(1);
    pulse_delay(d);
    chk("R3 R10 new code on next edge", d, 41);

    // R9: gating freezes line and output
    load(8'd3);
    idle(130);
    din = 1'b1;
    @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      din = k[0];
      @(negedge clk);
      chk("R9 frozen low", dout, 0);
    end
    din = 1'b0;
    en = 1'b1;
    d = 1;
    @(negedge clk);
    while (!dout && d < 20) begin
      @(negedge clk);
      d++;
    end
    chk("R9 remaining gated delay", d, 3);
    en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 frozen high", dout, 1);
    en = 1'b1;
    @(negedge clk);
    chk("R9 resume", dout, 0);
    idle(10);
    chk("R9 no stray pulse", dout, 0);

    // R2 / R9: random stream against reference history
    for (int pass = 0; pass < 2; pass++) begin
      ref_code = pass ? 100 : 13;
      load(8'(ref_code));
      idle(130);
      for (int t = 0; t < 400; t++) begin
        din = 1'($urandom);
        en = ($urandom % 4) != 0;
        @(negedge clk);
        if (dout !== exp_q) chk("R2 R9 stream", dout, exp_q);
      end
      en = 1'b1;
      checks++;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule